// File: doc/BRIEF.md
# Serial Flash Command and Status Controller

This block is the slave-side command front end of a serial NOR flash emulator. A host drives chip select, serial clock and data-in; the block samples these on the system clock, shifts in one bit on every falling serial-clock edge while chip select is low, decodes the 8-bit opcode, and answers reads of the status byte, the flag byte and a device identification stream on its serial data-out line. It owns the status register, including the write-enable latch (bit 1) and the busy bit (bit 0).

Program, erase and status-write commands are gated by the status register. A command that passes the gate is armed once its address or data phase is complete; when chip select then rises, the block issues a one-cycle start strobe with the operation kind and address to a separate program/erase engine, clears the write-enable latch, sets busy and loads a countdown whose length is a per-operation parameter. When the countdown ends, busy and the latch clear together. The memory array, data phases of programming, and quad-wide transfers belong to other blocks.

Top module: `sflash_cmd_ctrl`

## Requirements
- R1: Serial input is sampled on the falling serial-clock edge while chip select is low, most significant bit first. The output byte for a data phase is loaded on the falling edge that completes the previous byte (bit count a nonzero multiple of 8), its bit 7 is driven on the data-out line at once, and each later falling edge shifts it left. Chip select high clears the bit count and drives data-out low.
- R2: Opcode 0x06 sets status bit 1 (write-enable latch); opcode 0x04 clears it. Both are honoured while busy.
- R3: Opcodes 0x01, 0x02, 0x20, 0x32, 0x42, 0xC7 and 0xD8 are accepted only when status bits [1:0] are 2'b10. A refused one starts nothing, leaves the status register unchanged and returns 0x00 for the rest of the transaction.
- R4: An accepted command is armed after its opcode (0xC7), after 24 address bits (0x02, 0x32, 0x42, 0x20, 0xD8) or after its data byte (0x01). On the chip-select rise after arming, `wr_start` pulses for one cycle with `wr_kind` (0x02→0, 0x32→1, 0x42→2, 0x20→3, 0xD8→4, 0xC7→5, 0x01→6) and `wr_addr`; status bit 1 clears, bit 0 sets, and `flash_busy` stays high for exactly the operation's duration parameter in clock cycles.
- R5: When the countdown ends, status bits 1 and 0 both clear in the same cycle.
- R6: Opcode 0x05 returns the status register on every following byte while chip select stays low.
- R7: For opcode 0x01 the data byte takes effect at bit count 16 and replaces only status bits 6 to 2; if chip select rises before bit 16, the status register is unchanged and nothing starts.
- R8: After reset the status register is 0x1C and the flag register 0xA5. Opcode 0x70 returns the flag register on every following byte; opcode 0x50 clears flag bits 6 and 5 when chip select rises.
- R9: Opcodes 0x9E and 0x9F stream an identification table of ID_LEN bytes, one per byte slot: the manufacturer, type and capacity parameters, then ID_LEN-4, then 0xFE, 0xFD and so on downward; every byte after the table is 0x00.
- R10: Any opcode outside 0x01, 0x02, 0x04, 0x05, 0x06, 0x20, 0x32, 0x42, 0x50, 0x70, 0x9E, 0x9F, 0xC7, 0xD8 sets `cmd_err`, which stays set until reset; the rest of that transaction returns 0x00.
- R11: If the countdown ends in the same cycle as a 0x06 opcode completes, busy clears and the write-enable latch ends set; a status byte loaded in that cycle shows the value held before the cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are sampled on it |
| rst_n | input | 1 | Synchronous active-low reset |
| spi_cs_n | input | 1 | Chip select, active low |
| spi_sck | input | 1 | Serial clock from the host |
| spi_mosi | input | 1 | Serial data from the host |
| spi_miso | output | 1 | Serial data to the host |
| flash_busy | output | 1 | Status bit 0, a program/erase/status cycle is running |
| wr_start | output | 1 | One-cycle start strobe to the program/erase engine |
| wr_kind | output | 3 | Operation kind, valid with wr_start |
| wr_addr | output | 24 | Operation address, valid with wr_start |
| cmd_err | output | 1 | Sticky flag for an unrecognised opcode |

## Verification
The countdown expiry and the decode of a write-enable opcode both write the status register and can land in the same clock cycle; the design resolves this by letting the opcode set the latch after the expiry clears it. The bench provokes the overlap by starting a status-write cycle and then issuing 0x06 after a delay swept over sixteen values, so that the opcode's last falling edge walks across the expiry cycle. A behavioural model in the bench predicts the status, data-out and busy values cycle by cycle, the final status byte read for every delay is compared against it, and the bench requires that at least one sweep point hit the exact coincidence.

// File: rtl/sfc_pkg.sv
// Package: shared types and the identification table rule for the serial
// flash command controller. Assumes ID tables of at least four bytes.
package sfc_pkg;

    // Opcodes the decoder understands
    localparam logic [7:0] OP_WRSR  = 8'h01;
    localparam logic [7:0] OP_PROG  = 8'h02;
    localparam logic [7:0] OP_WRDI  = 8'h04;
    localparam logic [7:0] OP_RDSR  = 8'h05;
    localparam logic [7:0] OP_WREN  = 8'h06;
    localparam logic [7:0] OP_SUBER = 8'h20;
    localparam logic [7:0] OP_QPROG = 8'h32;
    localparam logic [7:0] OP_OTPPG = 8'h42;
    localparam logic [7:0] OP_CLRFL = 8'h50;
    localparam logic [7:0] OP_RDFL  = 8'h70;
    localparam logic [7:0] OP_ID_A  = 8'h9E;
    localparam logic [7:0] OP_ID_B  = 8'h9F;
    localparam logic [7:0] OP_BULK  = 8'hC7;
    localparam logic [7:0] OP_SECER = 8'hD8;

    localparam logic [7:0] SREG_RST  = 8'h1C;
    localparam logic [7:0] FLAG_RST  = 8'hA5;
    localparam logic [7:0] SREG_WMSK = 8'h7C;
    localparam logic [7:0] FLAG_CMSK = 8'h9F;

    // Operation kind handed to the program/erase engine
    typedef enum logic [2:0] {
        KIND_PAGE  = 3'd0,
        KIND_QPAGE = 3'd1,
        KIND_OTP   = 3'd2,
        KIND_SUB   = 3'd3,
        KIND_SECT  = 3'd4,
        KIND_BULK  = 3'd5,
        KIND_STAT  = 3'd6
    } wr_kind_e;

    // Transaction phase of the decoder
    typedef enum logic [3:0] {
        ST_OPC,    // waiting for the opcode
        ST_NULL,   // command done, remaining bits return zero
        ST_RDSR,   // streaming the status register
        ST_RDFL,   // streaming the flag register
        ST_RDID,   // streaming the identification table
        ST_CLRF,   // flag clear pending on chip-select rise
        ST_WRSR,   // waiting for the status data byte
        ST_ADDR,   // collecting 24 address bits
        ST_ARMED,  // write-class operation ready to start
        ST_BAD     // refused or unknown, rest ignored
    } dec_st_e;

    // Identification byte k of a table of len bytes
    function automatic logic [7:0] id_byte(input int unsigned k,
                                           input int unsigned len,
                                           input logic [7:0] mfr,
                                           input logic [7:0] typ,
                                           input logic [7:0] cap);
        if (k >= len) return 8'h00;
        case (k)
            0: return mfr;
            1: return typ;
            2: return cap;
            3: return 8'(len - 4);
            default: return 8'(32'd254 - (k - 4));
        endcase
    endfunction

endpackage

// File: rtl/sfc_shifter.sv
// Serial front end: samples the pins on the system clock, finds falling
// serial-clock edges and chip-select rises, counts bits, keeps the input
// shift register and drives the output shift register MSB first.
// Assumes the pins are already synchronous to clk and that the serial clock
// stays at least two system cycles in each level.
module sfc_shifter #(
    parameter int CNT_W = 16,
    parameter int IN_W  = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n_i,
    input  logic             sck_i,
    input  logic             mosi_i,
    input  logic             load_en,
    input  logic [7:0]       load_byte,
    output logic             fall,
    output logic             rise,
    output logic [CNT_W-1:0] nxt_cnt,
    output logic [IN_W-1:0]  nxt_ireg,
    output logic             miso
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic             cs_s, sck_s, mosi_s, cs_d, sck_d;
    logic [CNT_W-1:0] cnt_q;
    logic [IN_W-1:0]  ireg_q;
    logic [7:0]       oreg_q;

    // Pin sampling and one-cycle history for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cs_s <= 1'b1; sck_s <= 1'b0; mosi_s <= 1'b0;
            cs_d <= 1'b1; sck_d <= 1'b0;
        end else begin
            cs_s <= cs_n_i; sck_s <= sck_i; mosi_s <= mosi_i;
            cs_d <= cs_s;   sck_d <= sck_s;
        end
    end

    assign fall     = sck_d && !sck_s && !cs_s;
    assign rise     = !cs_d && cs_s;
    assign nxt_cnt  = (cnt_q == CNT_MAX) ? cnt_q : cnt_q + 1'b1;
    assign nxt_ireg = {ireg_q[IN_W-2:0], mosi_s};

    // Bit counter and input shift register, cleared while deselected
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            cnt_q  <= '0;
            ireg_q <= '0;
        end else if (fall) begin
            cnt_q  <= nxt_cnt;
            ireg_q <= nxt_ireg;
        end
    end

    // Output shift register: load on byte boundaries, shift otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || cs_s) begin
            oreg_q <= 8'h00;
        end else if (fall) begin
            oreg_q <= load_en ? load_byte : {oreg_q[6:0], 1'b0};
        end
    end

    assign miso = oreg_q[7];

    // R1
    cs_idle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s)) |=> (cnt_q == '0 && miso == 1'b0));

    // R1
    hold_no_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fall && !cs_s && !rst_n == 1'b0) |=> $stable(cnt_q) || $past(cs_s));

endmodule

// File: rtl/sfc_busy_timer.sv
// Busy countdown: loads a duration on request and counts down once per
// clock; expire is high in the cycle the count leaves one.
// Assumes every loaded duration is at least one.
module sfc_busy_timer #(
    parameter int W = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         expire
);
    logic [W-1:0] cnt_q;

    // Countdown register
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= load_val;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == W'(1));

    // R4
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == '0 && !load) |=> cnt_q == '0);

endmodule

// File: rtl/sfc_decoder.sv
// Command decoder: interprets the opcode and the later byte boundaries,
// owns the status and flag registers and the sticky error flag, gates
// write-class commands and arms the start strobe for the engine.
// Assumes fall and rise never occur in the same cycle.
module sfc_decoder
    import sfc_pkg::*;
#(
    parameter int          CNT_W   = 16,
    parameter int          IN_W    = 24,
    parameter int          TMR_W   = 24,
    parameter int          ID_LEN  = 20,
    parameter logic [7:0]  ID_MFR  = 8'h5A,
    parameter logic [7:0]  ID_TYPE = 8'h40,
    parameter logic [7:0]  ID_CAP  = 8'h18,
    parameter int          T_PROG  = 5000,
    parameter int          T_OTP   = 5000,
    parameter int          T_SUB   = 25000,
    parameter int          T_SECT  = 70000,
    parameter int          T_BULK  = 320000,
    parameter int          T_STAT  = 13000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall,
    input  logic             rise,
    input  logic [CNT_W-1:0] nxt_cnt,
    input  logic [IN_W-1:0]  nxt_ireg,
    input  logic             expire,
    output logic             load_en,
    output logic [7:0]       load_byte,
    output logic             tmr_load,
    output logic [TMR_W-1:0] tmr_val,
    output logic             wr_start,
    output logic [2:0]       wr_kind,
    output logic [23:0]      wr_addr,
    output logic             busy,
    output logic             err
);
    localparam int IDX_W = $clog2(ID_LEN + 1);
    localparam logic [IDX_W-1:0] IDX_END = IDX_W'(ID_LEN);

    dec_st_e          st_q, st_n;
    wr_kind_e         kind_q, kind_n;
    logic [7:0]       sreg_q, sreg_n, flag_q, flag_n;
    logic [23:0]      addr_q, addr_n;
    logic [IDX_W-1:0] idx_q, idx_n;
    logic             err_q, err_n;
    logic             start_q;
    logic             arm_rise, boundary, wren_hit, sr_apply;
    logic [7:0]       op;

    assign boundary = fall && (nxt_cnt[2:0] == 3'd0) && (nxt_cnt != '0);
    assign arm_rise = rise && (st_q == ST_ARMED);
    assign op       = nxt_ireg[7:0];

    // Next-state logic: expiry first, then chip-select rise or bit event
    always_comb begin
        st_n = st_q; kind_n = kind_q; sreg_n = sreg_q; flag_n = flag_q;
        addr_n = addr_q; idx_n = idx_q; err_n = err_q;
        load_en = 1'b0; load_byte = 8'h00; wren_hit = 1'b0; sr_apply = 1'b0;
        if (expire) sreg_n[1:0] = 2'b00;
        if (rise) begin
            if (arm_rise) sreg_n[1:0] = 2'b01;
            if (st_q == ST_CLRF) flag_n = flag_q & FLAG_CMSK;
            st_n = ST_OPC;
        end else if (boundary) begin
            load_en = 1'b1;
            if (st_q == ST_OPC && nxt_cnt == CNT_W'(8)) begin
                st_n = ST_NULL;
                case (op)
                    OP_WREN: begin sreg_n[1] = 1'b1; wren_hit = 1'b1; end
                    OP_WRDI: sreg_n[1] = 1'b0;
                    OP_RDSR: begin st_n = ST_RDSR; load_byte = sreg_q; end
                    OP_RDFL: begin st_n = ST_RDFL; load_byte = flag_q; end
                    OP_CLRFL: st_n = ST_CLRF;
                    OP_ID_A, OP_ID_B: begin
                        st_n = ST_RDID; idx_n = '0;
                        load_byte = id_byte(0, ID_LEN, ID_MFR, ID_TYPE, ID_CAP);
                    end
                    OP_WRSR, OP_PROG, OP_QPROG, OP_OTPPG,
                    OP_SUBER, OP_SECER, OP_BULK: begin
                        addr_n = '0;
                        if (sreg_q[1:0] != 2'b10) st_n = ST_BAD;
                        else begin
                            case (op)
                                OP_WRSR:  begin kind_n = KIND_STAT;  st_n = ST_WRSR;  end
                                OP_PROG:  begin kind_n = KIND_PAGE;  st_n = ST_ADDR;  end
                                OP_QPROG: begin kind_n = KIND_QPAGE; st_n = ST_ADDR;  end
                                OP_OTPPG: begin kind_n = KIND_OTP;   st_n = ST_ADDR;  end
                                OP_SUBER: begin kind_n = KIND_SUB;   st_n = ST_ADDR;  end
                                OP_SECER: begin kind_n = KIND_SECT;  st_n = ST_ADDR;  end
                                default:  begin kind_n = KIND_BULK;  st_n = ST_ARMED; end
                            endcase
                        end
                    end
                    default: begin err_n = 1'b1; st_n = ST_BAD; end
                endcase
            end else begin
                case (st_q)
                    ST_RDSR: load_byte = sreg_q;
                    ST_RDFL: load_byte = flag_q;
                    ST_RDID: begin
                        if (idx_q != IDX_END) idx_n = idx_q + 1'b1;
                        load_byte = id_byte(int'(idx_q) + 1, ID_LEN,
                                            ID_MFR, ID_TYPE, ID_CAP);
                    end
                    ST_WRSR: if (nxt_cnt == CNT_W'(16)) begin
                        sr_apply = 1'b1;
                        sreg_n = (sreg_n & ~SREG_WMSK) | (op & SREG_WMSK);
                        st_n = ST_ARMED;
                    end
                    ST_ADDR: if (nxt_cnt == CNT_W'(32)) begin
                        addr_n = nxt_ireg[23:0];
                        st_n = ST_ARMED;
                    end
                    ST_CLRF: st_n = ST_BAD;
                    default: ;
                endcase
            end
        end
    end

    // Decoder state and architectural registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_OPC; kind_q <= KIND_PAGE; sreg_q <= SREG_RST;
            flag_q <= FLAG_RST; addr_q <= '0; idx_q <= '0; err_q <= 1'b0;
            start_q <= 1'b0;
        end else begin
            st_q <= st_n; kind_q <= kind_n; sreg_q <= sreg_n;
            flag_q <= flag_n; addr_q <= addr_n; idx_q <= idx_n; err_q <= err_n;
            start_q <= arm_rise;
        end
    end

    // Duration of the armed operation
    always_comb begin
        case (kind_q)
            KIND_PAGE, KIND_QPAGE: tmr_val = TMR_W'(T_PROG);
            KIND_OTP:              tmr_val = TMR_W'(T_OTP);
            KIND_SUB:              tmr_val = TMR_W'(T_SUB);
            KIND_SECT:             tmr_val = TMR_W'(T_SECT);
            KIND_BULK:             tmr_val = TMR_W'(T_BULK);
            default:               tmr_val = TMR_W'(T_STAT);
        endcase
    end

    assign tmr_load = arm_rise;
    assign wr_start = start_q;
    assign wr_kind  = kind_q;
    assign wr_addr  = addr_q;
    assign busy     = sreg_q[0];
    assign err      = err_q;

    // R3
    start_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        arm_rise |-> (sreg_q[1:0] == 2'b10));

    // R4
    start_sets_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_start |-> (sreg_q[1:0] == 2'b01));

    // R5
    expire_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && !wren_hit) |=> (sreg_q[1:0] == 2'b00));

    // R11
    collide_wel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (expire && wren_hit) |=> (sreg_q[1:0] == 2'b10));

    // R7
    sr_fixed_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sr_apply |=> (sreg_q[7] == $past(sreg_q[7]) &&
                      sreg_q[1:0] == $past(sreg_q[1:0])));

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err_q |=> err_q);

endmodule

// File: rtl/sflash_cmd_ctrl.sv
// Top: serial flash command and status controller. Connects the serial
// front end, the command decoder and the busy countdown.
// Assumes pins synchronous to clk and durations of at least one cycle.
module sflash_cmd_ctrl #(
    parameter int          CNT_W   = 16,
    parameter int          TMR_W   = 24,
    parameter int          ID_LEN  = 20,
    parameter logic [7:0]  ID_MFR  = 8'h5A,
    parameter logic [7:0]  ID_TYPE = 8'h40,
    parameter logic [7:0]  ID_CAP  = 8'h18,
    parameter int          T_PROG  = 5000,
    parameter int          T_OTP   = 5000,
    parameter int          T_SUB   = 25000,
    parameter int          T_SECT  = 70000,
    parameter int          T_BULK  = 320000,
    parameter int          T_STAT  = 13000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        spi_cs_n,
    input  logic        spi_sck,
    input  logic        spi_mosi,
    output logic        spi_miso,
    output logic        flash_busy,
    output logic        wr_start,
    output logic [2:0]  wr_kind,
    output logic [23:0] wr_addr,
    output logic        cmd_err
);
    localparam int IN_W = 24;

    logic             fall, rise, load_en, tmr_load, expire;
    logic [7:0]       load_byte;
    logic [CNT_W-1:0] nxt_cnt;
    logic [IN_W-1:0]  nxt_ireg;
    logic [TMR_W-1:0] tmr_val;

    sfc_shifter #(.CNT_W(CNT_W), .IN_W(IN_W)) u_shift (
        .clk(clk), .rst_n(rst_n), .cs_n_i(spi_cs_n), .sck_i(spi_sck),
        .mosi_i(spi_mosi), .load_en(load_en), .load_byte(load_byte),
        .fall(fall), .rise(rise), .nxt_cnt(nxt_cnt), .nxt_ireg(nxt_ireg),
        .miso(spi_miso)
    );

    sfc_decoder #(
        .CNT_W(CNT_W), .IN_W(IN_W), .TMR_W(TMR_W), .ID_LEN(ID_LEN),
        .ID_MFR(ID_MFR), .ID_TYPE(ID_TYPE), .ID_CAP(ID_CAP),
        .T_PROG(T_PROG), .T_OTP(T_OTP), .T_SUB(T_SUB), .T_SECT(T_SECT),
        .T_BULK(T_BULK), .T_STAT(T_STAT)
    ) u_dec (
        .clk(clk), .rst_n(rst_n), .fall(fall), .rise(rise),
        .nxt_cnt(nxt_cnt), .nxt_ireg(nxt_ireg), .expire(expire),
        .load_en(load_en), .load_byte(load_byte), .tmr_load(tmr_load),
        .tmr_val(tmr_val), .wr_start(wr_start), .wr_kind(wr_kind),
        .wr_addr(wr_addr), .busy(flash_busy), .err(cmd_err)
    );

    sfc_busy_timer #(.W(TMR_W)) u_tmr (
        .clk(clk), .rst_n(rst_n), .load(tmr_load), .load_val(tmr_val),
        .expire(expire)
    );

endmodule

// File: tb/sflash_cmd_ctrl_tb.sv
module sflash_cmd_ctrl_tb;
    localparam int ID_LEN = 20;
    localparam int T_PROG = 200, T_OTP = 220, T_SUB = 240;
    localparam int T_SECT = 300, T_BULK = 600, T_STAT = 160;

    logic clk = 1'b0, rst_n = 1'b0;
    logic spi_cs_n = 1'b1, spi_sck = 1'b0, spi_mosi = 1'b0;
    logic spi_miso, flash_busy, wr_start, cmd_err;
    logic [2:0]  wr_kind;
    logic [23:0] wr_addr;

    always #2 clk = ~clk;

    sflash_cmd_ctrl #(.ID_LEN(ID_LEN), .T_PROG(T_PROG), .T_OTP(T_OTP),
        .T_SUB(T_SUB), .T_SECT(T_SECT), .T_BULK(T_BULK), .T_STAT(T_STAT)) u_dut (
        .clk(clk), .rst_n(rst_n), .spi_cs_n(spi_cs_n), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .flash_busy(flash_busy),
        .wr_start(wr_start), .wr_kind(wr_kind), .wr_addr(wr_addr),
        .cmd_err(cmd_err));

    int checks = 0, errors = 0;
    bit done = 0;

    task automatic chk(string req, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    bit m_cs_s = 1, m_sck_s = 0, m_mosi_s = 0, m_cs_d = 1, m_sck_d = 0;
    int m_cnt, m_st, m_idx, m_tmr, m_kind, m_coll;
    bit [23:0] m_ireg, m_addr;
    bit [7:0] m_sreg, m_flag, m_ob;
    bit m_err, m_start;

    function automatic bit [7:0] exp_id(int k);
        if (k >= ID_LEN) return 8'h00;
        if (k == 0) return 8'h5A;
        if (k == 1) return 8'h40;
        if (k == 2) return 8'h18;
        if (k == 3) return 8'(ID_LEN - 4);
        return 8'(254 - (k - 4));
    endfunction

    function automatic int m_dur(int k);
        case (k)
            0, 1: return T_PROG;
            2: return T_OTP;
            3: return T_SUB;
            4: return T_SECT;
            5: return T_BULK;
            default: return T_STAT;
        endcase
    endfunction

    // model phases: 0 opcode,1 null,2 status,3 flag,4 id,5 clear,6 sr data,7 addr,8 armed,9 bad
    always @(posedge clk) begin
        if (!rst_n) begin
            m_cs_s = 1; m_sck_s = 0; m_mosi_s = 0; m_cs_d = 1; m_sck_d = 0;
            m_cnt = 0; m_st = 0; m_idx = 0; m_tmr = 0; m_kind = 0;
            m_ireg = 0; m_addr = 0; m_sreg = 8'h1C; m_flag = 8'hA5; m_ob = 0;
            m_err = 0; m_start = 0;
        end else begin
            bit fl, rs, ex;
            bit [7:0] old_s, op;
            fl = m_sck_d && !m_sck_s && !m_cs_s;
            rs = !m_cs_d && m_cs_s;
            ex = (m_tmr == 1);
            old_s = m_sreg;
            m_start = 0;
            if (m_tmr > 0) m_tmr--;
            if (ex) m_sreg[1:0] = 0;
            if (rs) begin
                if (m_st == 8) begin
                    m_start = 1; m_sreg[1:0] = 2'b01; m_tmr = m_dur(m_kind);
                end
                if (m_st == 5) m_flag = m_flag & 8'h9F;
                m_st = 0;
            end
            if (m_cs_s) begin
                m_cnt = 0; m_ireg = 0; m_ob = 0;
            end else if (fl) begin
                m_cnt++;
                m_ireg = {m_ireg[22:0], m_mosi_s};
                op = m_ireg[7:0];
                if (m_cnt % 8 != 0) m_ob = m_ob << 1;
                else if (m_cnt == 8 && m_st == 0) begin
                    m_ob = 0; m_st = 1;
                    if (op == 8'h06) begin m_sreg[1] = 1; if (ex) m_coll++; end
                    else if (op == 8'h04) m_sreg[1] = 0;
                    else if (op == 8'h05) begin m_st = 2; m_ob = old_s; end
                    else if (op == 8'h70) begin m_st = 3; m_ob = m_flag; end
                    else if (op == 8'h50) m_st = 5;
                    else if (op == 8'h9E || op == 8'h9F) begin m_st = 4; m_idx = 0; m_ob = exp_id(0); end
                    else if (op inside {8'h01, 8'h02, 8'h32, 8'h42, 8'h20, 8'hD8, 8'hC7}) begin
                        m_addr = 0;
                        if (old_s[1:0] != 2'b10) m_st = 9;
                        else begin
                            m_st = 7;
                            case (op)
                                8'h01: begin m_kind = 6; m_st = 6; end
                                8'h02: m_kind = 0;
                                8'h32: m_kind = 1;
                                8'h42: m_kind = 2;
                                8'h20: m_kind = 3;
                                8'hD8: m_kind = 4;
                                default: begin m_kind = 5; m_st = 8; end
                            endcase
                        end
                    end else begin m_err = 1; m_st = 9; end
                end else begin
                    m_ob = 0;
                    if (m_st == 2) m_ob = old_s;
                    else if (m_st == 3) m_ob = m_flag;
                    else if (m_st == 4) begin
                        if (m_idx < ID_LEN) m_idx++;
                        m_ob = exp_id(m_idx);
                    end else if (m_st == 6 && m_cnt == 16) begin
                        m_sreg = (m_sreg & 8'h83) | (op & 8'h7C); m_st = 8;
                    end else if (m_st == 7 && m_cnt == 32) begin
                        m_addr = m_ireg; m_st = 8;
                    end else if (m_st == 5) m_st = 9;
                end
            end
            m_cs_d = m_cs_s; m_sck_d = m_sck_s;
            m_cs_s = spi_cs_n; m_sck_s = spi_sck; m_mosi_s = spi_mosi;
        end
    end

    // per-cycle comparison against the model, away from the active edge
    int starts = 0, last_kind, last_addr, busy_len = 0, busy_run = 0;
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("R1 miso", spi_miso, m_ob[7]);
            chk("R4 flash_busy", flash_busy, m_sreg[0]);
            chk("R4 wr_start", wr_start, m_start);
            chk("R10 cmd_err", cmd_err, m_err);
            if (wr_start) begin
                starts++; last_kind = wr_kind; last_addr = wr_addr;
                chk("R4 wr_kind", wr_kind, m_kind);
                chk("R4 wr_addr", wr_addr, m_addr);
                busy_run = 0;
            end
            if (flash_busy) busy_run++;
            else if (busy_run != 0) begin busy_len = busy_run; busy_run = 0; end
        end
    end

    // ---------------- serial host tasks ----------------
    bit [7:0] rx [0:31];

    task automatic wclk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic xbit(bit b, output bit r);
        wclk(2); spi_mosi = b; wclk(2);
        r = spi_miso; spi_sck = 1; wclk(4); spi_sck = 0;
    endtask

    task automatic xbyte(bit [7:0] tx, output bit [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            bit b;
            xbit(tx[i], b);
            r = {r[6:0], b};
        end
    endtask

    task automatic cs_lo(); spi_cs_n = 0; wclk(4); endtask
    task automatic cs_hi(); wclk(4); spi_cs_n = 1; wclk(8); endtask

    // opcode, then n bytes of tx data (d0..d2, zero beyond), replies in rx
    task automatic cmd(bit [7:0] op, int n, bit [7:0] d0 = 0, bit [7:0] d1 = 0, bit [7:0] d2 = 0);
        bit [7:0] r;
        cs_lo();
        xbyte(op, r);
        for (int i = 0; i < n; i++) begin
            xbyte(i == 0 ? d0 : i == 1 ? d1 : i == 2 ? d2 : 8'h00, r);
            rx[i] = r;
        end
        cs_hi();
    endtask

    task automatic wait_idle();
        while (flash_busy) @(negedge clk);
        wclk(4);
    endtask

    // ---------------- directed sequence ----------------
    initial begin
        int s0;
        wclk(5); rst_n = 1; wclk(4);
        // reset state
        chk("R8 reset busy", flash_busy, 0);
        chk("R10 reset err", cmd_err, 0);
        chk("R1 reset miso", spi_miso, 0);
        cmd(8'h05, 2);
        chk("R8 status reset", rx[0], 8'h1C);
        chk("R6 status repeat", rx[1], 8'h1C);
        cmd(8'h70, 2);
        chk("R8 flag reset", rx[0], 8'hA5);
        chk("R8 flag repeat", rx[1], 8'hA5);
        // identification stream and its tail
        cmd(8'h9F, 22);
        for (int k = 0; k < 22; k++) chk("R9 id byte", rx[k], exp_id(k));
        cmd(8'h9E, 2);
        chk("R9 alt id opcode", rx[1], exp_id(1));
        // refused erase without the latch
        s0 = starts;
        cmd(8'hD8, 3, 8'h12, 8'h34, 8'h56);
        chk("R3 refused start", starts, s0);
        cmd(8'h05, 1);
        chk("R3 refused status", rx[0], 8'h1C);
        // latch set and clear
        cmd(8'h06, 0); cmd(8'h05, 1);
        chk("R2 wren", rx[0], 8'h1E);
        cmd(8'h04, 0); cmd(8'h05, 1);
        chk("R2 wrdi", rx[0], 8'h1C);
        // sector erase
        s0 = starts;
        cmd(8'h06, 0); cmd(8'hD8, 3, 8'h12, 8'h34, 8'h56);
        chk("R4 erase start", starts, s0 + 1);
        chk("R4 erase kind", last_kind, 4);
        chk("R4 erase addr", last_addr, 24'h123456);
        cmd(8'h05, 1);
        chk("R4 busy status", rx[0], 8'h1D);
        wait_idle();
        chk("R4 busy length", busy_len, T_SECT);
        cmd(8'h05, 1);
        chk("R5 status after", rx[0], 8'h1C);
        // bulk erase, latch set while busy, program refused while busy
        cmd(8'h06, 0); cmd(8'hC7, 0);
        chk("R4 bulk kind", last_kind, 5);
        s0 = starts;
        cmd(8'h06, 0); cmd(8'h05, 1);
        chk("R2 wren while busy", rx[0], 8'h1F);
        cmd(8'h02, 4, 8'h00, 8'h01, 8'h00);
        chk("R3 busy refuses program", starts, s0);
        wait_idle();
        chk("R4 bulk length", busy_len, T_BULK);
        cmd(8'h05, 1);
        chk("R5 both bits clear", rx[0], 8'h1C);
        // quad program kind and address
        cmd(8'h06, 0); cmd(8'h32, 4, 8'hAB, 8'hCD, 8'hEF);
        chk("R4 qprog kind", last_kind, 1);
        chk("R4 qprog addr", last_addr, 24'hABCDEF);
        wait_idle();
        // status write
        cmd(8'h06, 0); cmd(8'h01, 1, 8'hFF);
        chk("R7 status kind", last_kind, 6);
        cmd(8'h05, 1);
        chk("R7 masked write", rx[0], 8'h7D);
        wait_idle();
        cmd(8'h05, 1);
        chk("R7 after write", rx[0], 8'h7C);
        s0 = starts;
        cmd(8'h06, 0); cmd(8'h01, 0);
        chk("R7 short write no start", starts, s0);
        cmd(8'h05, 1);
        chk("R7 short write unchanged", rx[0], 8'h7E);
        cmd(8'h01, 1, 8'h1C); wait_idle();
        cmd(8'h05, 1);
        chk("R7 restore", rx[0], 8'h1C);
        // flag clear
        cmd(8'h50, 0); cmd(8'h70, 2);
        chk("R8 flag cleared", rx[0], 8'h85);
        chk("R8 flag cleared repeat", rx[1], 8'h85);
        // unknown opcode
        cmd(8'h3C, 2);
        chk("R10 unknown data", rx[0], 8'h00);
        chk("R10 err set", cmd_err, 1);
        cmd(8'h05, 1);
        chk("R10 err sticky", cmd_err, 1);
        // expiry and write-enable collision sweep
        for (int d = 80; d < 96; d++) begin
            cmd(8'h06, 0); cmd(8'h01, 1, 8'h1C);
            wclk(d);
            cmd(8'h06, 0);
            wait_idle();
            cmd(8'h05, 1);
            chk("R11 status after overlap", rx[0], m_sreg);
            cmd(8'h04, 0);
        end
        chk("R11 overlap provoked", m_coll > 0, 1);
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++; errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule